// File: doc/BRIEF.md
# Sync Timing Measurement Unit

This block measures the timing of a horizontal and a vertical sync signal using a free-running crystal clock. Control logic uses the results to identify a video mode. Both sync inputs arrive asynchronously. Each passes through a two-flop synchronizer, and all edge detection works on the synchronized levels. Sync pulses are treated as active high.

The horizontal results are sums taken over 16 back-to-back periods or pulses. This gives a resolution of one sixteenth of a crystal clock. The vertical results are 12-bit counts. A unit-select input chooses what they count: either horizontal sync rising edges (lines) or whole blocks of 512 crystal clocks. Each result register is replaced in one step when its measurement window closes. Counts stop at all ones instead of wrapping.

Each input also has an activity flag. Control logic uses these flags to see which sync sources are present.

Top module: `sync_timing_meter`

## Requirements
- R1: While reset is high, and after its release until a result is published, every result is 0, every valid flag is 0 and both activity flags are 0.
- R2: `h_period_sum` equals the number of crystal clocks spanning 16 consecutive HSYNC periods (16×P for period P). Windows follow each other without gaps, and the value is replaced at every 16th rising edge after the arming edge.
- R3: `h_width_sum` equals the number of crystal clocks during which HSYNC is high, summed over 16 consecutive pulses (16×W for width W). The value is replaced at the falling edge that ends the 16th pulse.
- R4: With the unit bit at 0 (lines), `v_period_cnt` is the number of HSYNC rising edges between two successive VSYNC rising edges. The value is replaced at the VSYNC rising edge. An HSYNC edge in the same cycle as that VSYNC edge counts toward the frame that is ending.
- R5: With the unit bit at 0, `v_width_cnt` is the number of HSYNC rising edges seen while VSYNC is high after its rising edge. The value is replaced at the VSYNC falling edge.
- R6: With the unit bit at 1, both vertical results count complete blocks of 512 crystal clocks, i.e. floor(duration/512). The block counter restarts at every VSYNC rising edge.
- R7: The unit bit is sampled at each VSYNC rising edge and governs the whole frame that begins there. A change in mid-frame takes effect from the next frame.
- R8: Every accumulator saturates at all ones (65535 horizontal, 4095 vertical) rather than wrapping.
- R9: An activity flag rises after any edge on its synchronized input. It falls once 2^ACT_TO_W crystal clocks pass with no edge (default ACT_TO_W = 20).
- R10: A valid flag rises when its result is first published. Valid flags clear, and measurement re-arms, when the related input goes inactive. Result values are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Horizontal sync, asynchronous, active high |
| vsync_in | input | 1 | Vertical sync, asynchronous, active high |
| vunit_clk512 | input | 1 | Vertical unit select: 0 = lines, 1 = 512-clock blocks |
| h_period_sum | output | 16 | Crystal clocks over 16 HSYNC periods |
| h_period_valid | output | 1 | Horizontal period result present |
| h_width_sum | output | 16 | Crystal clocks high over 16 HSYNC pulses |
| h_width_valid | output | 1 | Horizontal width result present |
| v_period_cnt | output | 12 | Frame length in selected units |
| v_period_valid | output | 1 | Vertical period result present |
| v_width_cnt | output | 12 | VSYNC pulse length in selected units |
| v_width_valid | output | 1 | Vertical width result present |
| hsync_active | output | 1 | HSYNC edges seen recently |
| vsync_active | output | 1 | VSYNC edges seen recently |

## Verification
Two line formats are used. They differ in period, pulse width, lines per frame and VSYNC length. This shows that each result tracks its own input dimension and not a fixed constant. Each format is measured in both unit modes, with frame lengths chosen so the 512-clock floor differs from the line count. A mid-frame change of the unit bit shows that the bit is latched per frame. A long silence tests loss of activity, clearing of the valid flags and retention of the results. A line longer than 4096 clocks then drives both horizontal sums past 16 bits, which tests saturation against wrapping.

// File: rtl/stm_pkg.sv
package stm_pkg;

    // Synchronized sync level plus its edges, one cycle wide
    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } sync_ev_t;

    // Vertical measurement unit
    typedef enum logic {
        VU_LINES  = 1'b0,
        VU_CLK512 = 1'b1
    } vunit_e;

endpackage

// File: rtl/stm_sync_edge.sv
module stm_sync_edge
    import stm_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     din,
    output sync_ev_t ev
);
    logic [STAGES-1:0] pipe;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
            last <= 1'b0;
        end else begin
            pipe <= {pipe[STAGES-2:0], din};
            last <= pipe[STAGES-1];
        end
    end

    assign ev.lvl  = pipe[STAGES-1];
    assign ev.rise = pipe[STAGES-1] & ~last;
    assign ev.fall = ~pipe[STAGES-1] & last;
endmodule

// File: rtl/stm_activity.sv
module stm_activity
    import stm_pkg::*;
#(
    parameter int TO_W = 20
) (
    input  logic     clk,
    input  logic     rst,
    input  sync_ev_t ev,
    output logic     active
);
    logic [TO_W-1:0] idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle   <= '1;
            active <= 1'b0;
        end else if (ev.rise || ev.fall) begin
            idle   <= '0;
            active <= 1'b1;
        end else if (idle == '1) begin
            active <= 1'b0;
        end else begin
            idle <= idle + 1'b1;
        end
    end
endmodule

// File: rtl/stm_hmeas.sv
module stm_hmeas
    import stm_pkg::*;
#(
    parameter int SUM_W    = 16,
    parameter int WIN_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  sync_ev_t         ev,
    input  logic             active,
    output logic [SUM_W-1:0] per_sum,
    output logic             per_valid,
    output logic [SUM_W-1:0] wid_sum,
    output logic             wid_valid
);
    logic [SUM_W-1:0]    per_acc, wid_acc;
    logic [WIN_LOG2-1:0] per_n, wid_n;
    logic                per_arm, wid_arm;

    function automatic logic [SUM_W-1:0] bump(input logic [SUM_W-1:0] v);
        return (v == '1) ? v : v + 1'b1;
    endfunction

    // Period: clocks from the arming rise through 2^WIN_LOG2 periods
    always_ff @(posedge clk) begin
        if (rst) begin
            per_acc   <= '0;
            per_n     <= '0;
            per_arm   <= 1'b0;
            per_sum   <= '0;
            per_valid <= 1'b0;
        end else if (ev.rise) begin
            if (per_arm && per_n == '1) begin
                per_sum   <= per_acc;
                per_valid <= 1'b1;
                per_n     <= '0;
                per_acc   <= SUM_W'(1);
            end else if (per_arm) begin
                per_n   <= per_n + 1'b1;
                per_acc <= bump(per_acc);
            end else begin
                per_arm <= 1'b1;
                per_n   <= '0;
                per_acc <= SUM_W'(1);
            end
        end else if (!active) begin
            per_arm   <= 1'b0;
            per_valid <= 1'b0;
        end else if (per_arm) begin
            per_acc <= bump(per_acc);
        end
    end

    // Width: high clocks over 2^WIN_LOG2 complete pulses
    always_ff @(posedge clk) begin
        if (rst) begin
            wid_acc   <= '0;
            wid_n     <= '0;
            wid_arm   <= 1'b0;
            wid_sum   <= '0;
            wid_valid <= 1'b0;
        end else if (ev.fall && wid_arm) begin
            if (wid_n == '1) begin
                wid_sum   <= wid_acc;
                wid_valid <= 1'b1;
                wid_n     <= '0;
                wid_acc   <= '0;
            end else begin
                wid_n <= wid_n + 1'b1;
            end
        end else if (ev.rise) begin
            if (wid_arm) begin
                wid_acc <= bump(wid_acc);
            end else begin
                wid_arm <= 1'b1;
                wid_n   <= '0;
                wid_acc <= SUM_W'(1);
            end
        end else if (!active) begin
            wid_arm   <= 1'b0;
            wid_valid <= 1'b0;
        end else if (wid_arm && ev.lvl) begin
            wid_acc <= bump(wid_acc);
        end
    end
endmodule

// File: rtl/stm_vmeas.sv
module stm_vmeas
    import stm_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int UNIT_LOG2 = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  sync_ev_t         vs_ev,
    input  logic             hs_rise,
    input  logic             unit_sel,
    input  logic             active,
    output logic [CNT_W-1:0] per_cnt,
    output logic             per_valid,
    output logic [CNT_W-1:0] wid_cnt,
    output logic             wid_valid
);
    vunit_e               unit_q;
    logic [UNIT_LOG2-1:0] pre;
    logic [CNT_W-1:0]     pacc, wacc;
    logic                 arm;
    logic                 tick;

    assign tick = (unit_q == VU_CLK512) ? (pre == '1) : hs_rise;

    function automatic logic [CNT_W-1:0] adv(input logic [CNT_W-1:0] v, input logic t);
        return (t && v != '1) ? v + 1'b1 : v;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            unit_q    <= VU_LINES;
            pre       <= '0;
            pacc      <= '0;
            wacc      <= '0;
            arm       <= 1'b0;
            per_cnt   <= '0;
            per_valid <= 1'b0;
            wid_cnt   <= '0;
            wid_valid <= 1'b0;
        end else begin
            pre <= vs_ev.rise ? '0 : pre + 1'b1;
            if (vs_ev.rise) begin
                if (arm) begin
                    per_cnt   <= adv(pacc, tick);
                    per_valid <= 1'b1;
                end
                pacc   <= '0;
                wacc   <= '0;
                arm    <= 1'b1;
                unit_q <= vunit_e'(unit_sel);
            end else if (!active) begin
                arm       <= 1'b0;
                per_valid <= 1'b0;
                wid_valid <= 1'b0;
            end else if (arm) begin
                pacc <= adv(pacc, tick);
                if (vs_ev.fall) begin
                    wid_cnt   <= wacc;
                    wid_valid <= 1'b1;
                end else if (vs_ev.lvl) begin
                    wacc <= adv(wacc, tick);
                end
            end
        end
    end
endmodule

// File: rtl/sync_timing_meter.sv
module sync_timing_meter
    import stm_pkg::*;
#(
    parameter int HSUM_W      = 16,
    parameter int HWIN_LOG2   = 4,
    parameter int VCNT_W      = 12,
    parameter int VUNIT_LOG2  = 9,
    parameter int ACT_TO_W    = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hsync_in,
    input  logic              vsync_in,
    input  logic              vunit_clk512,
    output logic [HSUM_W-1:0] h_period_sum,
    output logic              h_period_valid,
    output logic [HSUM_W-1:0] h_width_sum,
    output logic              h_width_valid,
    output logic [VCNT_W-1:0] v_period_cnt,
    output logic              v_period_valid,
    output logic [VCNT_W-1:0] v_width_cnt,
    output logic              v_width_valid,
    output logic              hsync_active,
    output logic              vsync_active
);
    localparam int NUM_IN = 2;

    logic [NUM_IN-1:0] raw_in;
    sync_ev_t          ev  [NUM_IN];
    logic [NUM_IN-1:0] act;
    sync_ev_t          hs_ev, vs_ev;

    assign raw_in = {vsync_in, hsync_in};

    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_in
        stm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .din (raw_in[gi]),
            .ev  (ev[gi])
        );
        stm_activity #(.TO_W(ACT_TO_W)) u_act (
            .clk    (clk),
            .rst    (rst),
            .ev     (ev[gi]),
            .active (act[gi])
        );
    end

    assign hs_ev        = ev[0];
    assign vs_ev        = ev[1];
    assign hsync_active = act[0];
    assign vsync_active = act[1];

    stm_hmeas #(.SUM_W(HSUM_W), .WIN_LOG2(HWIN_LOG2)) u_h (
        .clk       (clk),
        .rst       (rst),
        .ev        (hs_ev),
        .active    (act[0]),
        .per_sum   (h_period_sum),
        .per_valid (h_period_valid),
        .wid_sum   (h_width_sum),
        .wid_valid (h_width_valid)
    );

    stm_vmeas #(.CNT_W(VCNT_W), .UNIT_LOG2(VUNIT_LOG2)) u_v (
        .clk       (clk),
        .rst       (rst),
        .vs_ev     (vs_ev),
        .hs_rise   (hs_ev.rise),
        .unit_sel  (vunit_clk512),
        .active    (act[1]),
        .per_cnt   (v_period_cnt),
        .per_valid (v_period_valid),
        .wid_cnt   (v_width_cnt),
        .wid_valid (v_width_valid)
    );
endmodule

// File: rtl/stm_checker.sv
module stm_checker
    import stm_pkg::*;
#(
    parameter int HSUM_W   = 16,
    parameter int VCNT_W   = 12,
    parameter int ACT_TO_W = 20
) (
    input logic              clk,
    input logic              rst,
    input sync_ev_t          hs_ev,
    input sync_ev_t          vs_ev,
    input logic [HSUM_W-1:0] h_period_sum,
    input logic              h_period_valid,
    input logic              h_width_valid,
    input logic [VCNT_W-1:0] v_period_cnt,
    input logic [VCNT_W-1:0] v_width_cnt,
    input logic              hsync_active,
    input logic              vsync_active
);
    localparam logic [ACT_TO_W:0] LIM = {1'b1, {ACT_TO_W{1'b0}}};

    logic [ACT_TO_W:0] hs_idle, vs_idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_idle <= '0;
            vs_idle <= '0;
        end else begin
            if (hs_ev.rise || hs_ev.fall) hs_idle <= '0;
            else if (hs_idle != LIM)      hs_idle <= hs_idle + 1'b1;
            if (vs_ev.rise || vs_ev.fall) vs_idle <= '0;
            else if (vs_idle != LIM)      vs_idle <= vs_idle + 1'b1;
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (h_period_sum == '0 && !h_period_valid && !hsync_active && !vsync_active));

    assert_hper_publish_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(h_period_sum) |-> h_period_valid);

    assert_vper_on_rise_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(v_period_cnt) |-> $past(vs_ev.rise));

    assert_vwid_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(v_width_cnt) |-> $past(vs_ev.fall));

    assert_hs_timeout_R9: assert property (@(posedge clk) disable iff (rst)
        (hs_idle == LIM) |-> !hsync_active);

    assert_vs_timeout_R9: assert property (@(posedge clk) disable iff (rst)
        (vs_idle == LIM) |-> !vsync_active);

    assert_edge_wakes_R9: assert property (@(posedge clk) disable iff (rst)
        (hs_ev.rise || hs_ev.fall) |=> hsync_active);

    assert_valid_drop_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(hsync_active) |=> ((!h_period_valid && !h_width_valid) || hsync_active));
endmodule

bind sync_timing_meter stm_checker #(
    .HSUM_W   (HSUM_W),
    .VCNT_W   (VCNT_W),
    .ACT_TO_W (ACT_TO_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .hs_ev          (hs_ev),
    .vs_ev          (vs_ev),
    .h_period_sum   (h_period_sum),
    .h_period_valid (h_period_valid),
    .h_width_valid  (h_width_valid),
    .v_period_cnt   (v_period_cnt),
    .v_width_cnt    (v_width_cnt),
    .hsync_active   (hsync_active),
    .vsync_active   (vsync_active)
);

// File: tb/sync_timing_meter_tb_top.sv
module sync_timing_meter_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hs = 1'b0;
    logic        vs = 1'b0;
    logic        unit = 1'b0;
    logic [15:0] h_per, h_wid;
    logic [11:0] v_per, v_wid;
    logic        h_per_v, h_wid_v, v_per_v, v_wid_v, hs_act, vs_act;
    int          checks = 0;
    int          fails = 0;

    always #10 clk = ~clk;

    sync_timing_meter #(.ACT_TO_W(13)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .hsync_in       (hs),
        .vsync_in       (vs),
        .vunit_clk512   (unit),
        .h_period_sum   (h_per),
        .h_period_valid (h_per_v),
        .h_width_sum    (h_wid),
        .h_width_valid  (h_wid_v),
        .v_period_cnt   (v_per),
        .v_period_valid (v_per_v),
        .v_width_cnt    (v_wid),
        .v_width_valid  (v_wid_v),
        .hsync_active   (hs_act),
        .vsync_active   (vs_act)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic gen_hlines(input int n, input int p, input int w);
        for (int l = 0; l < n; l++)
            for (int c = 0; c < p; c++) begin
                @(negedge clk);
                hs = (c < w);
            end
    endtask

    // One frame: VSYNC rises mid line 0 and falls mid line v; unit bit set at line 2
    task automatic gen_frame(input int lines, input int v, input int p, input int w,
                             input logic new_unit);
        for (int l = 0; l < lines; l++)
            for (int c = 0; c < p; c++) begin
                @(negedge clk);
                hs = (c < w);
                if (c == w + 5 && l == 0) vs = 1'b1;
                if (c == w + 5 && l == v) vs = 1'b0;
                if (c == 0 && l == 2) unit = new_unit;
            end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 h_per in reset", h_per, 0);
        chk("R1 v_per in reset", v_per, 0);
        chk("R1 valids in reset", {h_per_v, h_wid_v, v_per_v, v_wid_v}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 results after reset", {h_wid, v_wid}, 0);
        chk("R1 activity after reset", {hs_act, vs_act}, 0);
    endtask

    task automatic t_lines_a;
        repeat (3) gen_frame(30, 8, 100, 10, 1'b0);
        chk("R2 h period 16x100", h_per, 1600);
        chk("R3 h width 16x10", h_wid, 160);
        chk("R4 v period lines", v_per, 30);
        chk("R5 v width lines", v_wid, 8);
        chk("R10 all valid", {h_per_v, h_wid_v, v_per_v, v_wid_v}, 4'hF);
        chk("R9 both active", {hs_act, vs_act}, 2'b11);
    endtask

    task automatic t_unit_latch;
        gen_frame(30, 8, 100, 10, 1'b1);
        chk("R7 width keeps line unit", v_wid, 8);
        gen_frame(30, 8, 100, 10, 1'b1);
        chk("R7 period keeps line unit", v_per, 30);
        chk("R6 width 800 clk", v_wid, 1);
        gen_frame(30, 8, 100, 10, 1'b1);
        chk("R6 period 3000 clk", v_per, 5);
    endtask

    task automatic t_clock_b;
        repeat (3) gen_frame(25, 3, 77, 13, 1'b1);
        chk("R2 h period 16x77", h_per, 1232);
        chk("R3 h width 16x13", h_wid, 208);
        chk("R6 period 1925 clk", v_per, 3);
        chk("R6 width 231 clk", v_wid, 0);
        unit = 1'b0;
        repeat (3) gen_frame(25, 3, 77, 13, 1'b0);
        chk("R4 v period lines b", v_per, 25);
        chk("R5 v width lines b", v_wid, 3);
    endtask

    task automatic t_idle;
        hs = 1'b0;
        vs = 1'b0;
        repeat (9000) @(negedge clk);
        chk("R9 inactive after silence", {hs_act, vs_act}, 0);
        chk("R10 valids cleared", {h_per_v, h_wid_v, v_per_v, v_wid_v}, 0);
        chk("R10 h result kept", h_per, 1232);
        chk("R10 v result kept", v_per, 25);
    endtask

    task automatic t_saturate;
        gen_hlines(17, 4200, 4100);
        hs = 1'b0;
        repeat (10) @(negedge clk);
        chk("R8 h period saturates", h_per, 16'hFFFF);
        chk("R8 h width saturates", h_wid, 16'hFFFF);
        chk("R9 hs active again", hs_act, 1);
        chk("R9 vs still inactive", vs_act, 0);
        chk("R10 h valid after rearm", {h_per_v, h_wid_v}, 2'b11);
    endtask

    initial begin
        t_reset();
        t_lines_a();
        t_unit_latch();
        t_clock_b();
        t_idle();
        t_saturate();
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule